// File: doc/BRIEF.md
# Port-Limited Register File Sequencer

This block holds a small register file and runs one three-operand add at a time. The add reads two source registers, sums them and writes the sum to a destination register. A parameter sets how many access ports the register file has: 1, 2 or 3. Each port makes one access per cycle, so the sequencer places the two reads and the write over as many cycles as the port count needs. With one port it uses three cycles, with two ports it uses two, and with three ports it uses one.

The caller raises `reqValid` with two source indices and a destination index while `busy` is low. The block then holds `busy` until the write cycle. In that cycle it pulses `done` and shows the sum and the destination index. At reset each register is loaded with its own index, so the contents are known before any operation runs. Register 0 always reads as zero and cannot be written.

Top module: `rf_port_seq`

## Requirements
- R1: After reset `busy` and `done` are low and register i holds the value i (register 0 holds zero).
- R2: A request accepted at a clock edge (`reqValid` high, `busy` low) raises `done` in cycle 3, 2 or 1 after that edge for NPORTS = 1, 2 or 3.
- R3: `busy` is high in every cycle from the one after the accepting edge through the `done` cycle, and low in the cycle after `done`.
- R4: `done` lasts exactly one cycle for each accepted request, and stays low while no request is in progress.
- R5: In the `done` cycle, `resultData` equals the sum of the two source registers modulo 2^DW, and `resultDst` equals the destination index. That sum is then held by the destination register.
- R6: Register index 0 reads as zero. A result written to index 0 is discarded.
- R7: When a source index equals the destination index, the operation uses the register value from before its own write. This holds in every port configuration, including the single-cycle three-port case.
- R8: While `busy` is high, `reqValid` and the index inputs have no effect: no extra operation runs and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Operation request, accepted when `busy` is low |
| reqSrcA | input | AW | First source register index |
| reqSrcB | input | AW | Second source register index |
| reqDst | input | AW | Destination register index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse in the write cycle |
| resultData | output | DW | Sum being written, valid with `done` |
| resultDst | output | AW | Destination index, valid with `done` |

## Verification
The checker watches the handshake on every cycle. It confirms the latency for the configured port count, that `done` lasts one cycle and always falls inside `busy`, that `busy` holds until `done`, and that `busy` drops in the cycle after `done`. Register contents can only be seen through results. So the bench's scenarios are what show the sum with wrap-around, reads of the old value when indices alias, the zero register, and that requests made while busy leave the registers untouched. The bench runs all three port counts side by side on the same stimulus.

// File: rtl/rf_port_seq_pkg.sv
package rf_port_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READA = 2'd1,
    ST_READB = 2'd2,
    ST_WRITE = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic readA;
    logic readB;
    logic write;
  } seqStrobes_t;

endpackage

// File: rtl/rf_port_seq_regfile.sv
module rf_port_seq_regfile #(
  parameter int NPORTS = 2,
  parameter int AW     = 4,
  parameter int DW     = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NPORTS-1:0][AW-1:0]    portAddr,
  input  logic [NPORTS-1:0]            portWe,
  input  logic [NPORTS-1:0][DW-1:0]    portWdata,
  output logic [NPORTS-1:0][DW-1:0]    portRdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i);
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        if (portWe[p] && (portAddr[p] != '0)) mem[portAddr[p]] <= portWdata[p];
      end
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_read
    assign portRdata[p] = (portAddr[p] == '0) ? '0 : mem[portAddr[p]];
  end

endmodule

// File: rtl/rf_port_seq_ctrl.sv
module rf_port_seq_ctrl
  import rf_port_seq_pkg::*;
#(
  parameter int NPORTS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output seqStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  seqState_t state, stateNext;
  logic      accept;

  assign accept = (state == ST_IDLE) && reqValid;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        if (NPORTS >= 3)      stateNext = ST_WRITE;
        else                  stateNext = ST_READA;
      end
      ST_READA: stateNext = (NPORTS == 1) ? ST_READB : ST_WRITE;
      ST_READB: stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.capture = accept;
    strobes.readA   = (state == ST_READA) || ((state == ST_WRITE) && (NPORTS >= 3));
    strobes.readB   = (state == ST_READB)
                    || ((state == ST_READA) && (NPORTS == 2))
                    || ((state == ST_WRITE) && (NPORTS >= 3));
    strobes.write   = (state == ST_WRITE);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_WRITE);

endmodule

// File: rtl/rf_port_seq_dpath.sv
module rf_port_seq_dpath
  import rf_port_seq_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int AW     = 4,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobes_t   strobes,
  input  logic [AW-1:0] reqSrcA,
  input  logic [AW-1:0] reqSrcB,
  input  logic [AW-1:0] reqDst,
  output logic [DW-1:0] resultData,
  output logic [AW-1:0] resultDst
);
  localparam int B_PORT = (NPORTS > 1) ? 1 : 0;

  logic [AW-1:0] idxA, idxB, idxDst;
  logic [NPORTS-1:0][AW-1:0] portAddr;
  logic [NPORTS-1:0]         portWe;
  logic [NPORTS-1:0][DW-1:0] portWdata;
  logic [NPORTS-1:0][DW-1:0] portRdata;
  logic [DW-1:0] sum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxA   <= '0;
      idxB   <= '0;
      idxDst <= '0;
    end else if (strobes.capture) begin
      idxA   <= reqSrcA;
      idxB   <= reqSrcB;
      idxDst <= reqDst;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_wdata
    assign portWdata[p] = sum;
  end

  if (NPORTS == 1) begin : g_one
    logic [DW-1:0] opA, opB;
    always_comb begin
      if (strobes.write)      portAddr[0] = idxDst;
      else if (strobes.readB) portAddr[0] = idxB;
      else                    portAddr[0] = idxA;
    end
    assign portWe[0] = strobes.write;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        opA <= '0;
        opB <= '0;
      end else begin
        if (strobes.readA) opA <= portRdata[0];
        if (strobes.readB) opB <= portRdata[B_PORT];
      end
    end
    assign sum = opA + opB;
  end else if (NPORTS == 2) begin : g_two
    logic [DW-1:0] opA, opB;
    assign portAddr[0] = strobes.write ? idxDst : idxA;
    assign portAddr[1] = idxB;
    assign portWe      = {1'b0, strobes.write};
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        opA <= '0;
        opB <= '0;
      end else begin
        if (strobes.readA) opA <= portRdata[0];
        if (strobes.readB) opB <= portRdata[B_PORT];
      end
    end
    assign sum = opA + opB;
  end else begin : g_three
    // reads and write share one cycle; reads see pre-edge contents
    assign portAddr[0] = idxA;
    assign portAddr[1] = idxB;
    assign portAddr[2] = idxDst;
    assign portWe      = {strobes.write, 2'b00};
    assign sum         = portRdata[0] + portRdata[1];
  end

  rf_port_seq_regfile #(
    .NPORTS (NPORTS),
    .AW     (AW),
    .DW     (DW)
  ) u_regfile (
    .clk       (clk),
    .rstN      (rstN),
    .portAddr  (portAddr),
    .portWe    (portWe),
    .portWdata (portWdata),
    .portRdata (portRdata)
  );

  assign resultData = sum;
  assign resultDst  = idxDst;

endmodule

// File: rtl/rf_port_seq.sv
module rf_port_seq
  import rf_port_seq_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int AW     = 4,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [AW-1:0] reqSrcA,
  input  logic [AW-1:0] reqSrcB,
  input  logic [AW-1:0] reqDst,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] resultData,
  output logic [AW-1:0] resultDst
);
  seqStrobes_t strobes;

  rf_port_seq_ctrl #(.NPORTS(NPORTS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  rf_port_seq_dpath #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqSrcA    (reqSrcA),
    .reqSrcB    (reqSrcB),
    .reqDst     (reqDst),
    .resultData (resultData),
    .resultDst  (resultDst)
  );

endmodule

// File: rtl/rf_port_seq_chk.sv
module rf_port_seq_chk #(
  parameter int NPORTS = 2
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic busy,
  input logic done
);
  logic accepted;
  assign accepted = reqValid && !busy;

  // R2: latency set by port count
  if (NPORTS >= 3) begin : g_lat3
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
      accepted |=> done);
  end else if (NPORTS == 2) begin : g_lat2
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
      accepted |=> !done ##1 done);
  end else begin : g_lat1
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
      accepted |=> !done ##1 !done ##1 done);
  end

  // R3: busy rises on acceptance, holds until done, falls after done
  assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> busy);
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  assert_busy_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R4: done is a single-cycle pulse inside busy
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_in_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

bind rf_port_seq rf_port_seq_chk #(.NPORTS(NPORTS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .busy     (busy),
  .done     (done)
);

// File: tb/rf_port_seq_tb.sv
module rf_port_seq_tb;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NREG = 2 ** AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN;
  logic [2:0]    reqV;
  logic [AW-1:0] sA, sB, dI;
  logic [2:0]    busyV, doneV;
  logic [DW-1:0] dataV [3];
  logic [AW-1:0] dstV  [3];

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NREG];

  // index 0: one port, 1: two ports, 2: three ports
  rf_port_seq #(.NPORTS(1), .AW(AW), .DW(DW)) u_dutP1 (
    .clk(clk), .rstN(rstN), .reqValid(reqV[0]), .reqSrcA(sA), .reqSrcB(sB),
    .reqDst(dI), .busy(busyV[0]), .done(doneV[0]), .resultData(dataV[0]),
    .resultDst(dstV[0]));
  rf_port_seq #(.NPORTS(2), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqV[1]), .reqSrcA(sA), .reqSrcB(sB),
    .reqDst(dI), .busy(busyV[1]), .done(doneV[1]), .resultData(dataV[1]),
    .resultDst(dstV[1]));
  rf_port_seq #(.NPORTS(3), .AW(AW), .DW(DW)) u_dutP3 (
    .clk(clk), .rstN(rstN), .reqValid(reqV[2]), .reqSrcA(sA), .reqSrcB(sB),
    .reqDst(dI), .busy(busyV[2]), .done(doneV[2]), .resultData(dataV[2]),
    .resultDst(dstV[2]));

  task automatic chk(input string tag, input string what, input int inst,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s ports=%0d actual=%0d expected=%0d", tag, what, inst + 1, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One operation on all three instances; noise keeps a junk request up while busy.
  task automatic runOp(input int a, input int b, input int d, input bit noise,
                       input string dataTag);
    logic [DW-1:0] expSum;
    expSum = model[a] + model[b];
    @(negedge clk);
    sA = AW'(a); sB = AW'(b); dI = AW'(d); reqV = 3'b111;
    @(negedge clk);
    if (noise) begin
      sA = AW'(1); sB = AW'(2); dI = AW'(5);
    end else begin
      reqV = 3'b000;
    end
    for (int k = 1; k <= 4; k++) begin
      if (k > 1) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        int lat;
        lat = 3 - i;
        chk("R3", "busy", i, busyV[i], (k <= lat) ? 1 : 0);
        chk((k == lat) ? "R2" : "R4", "done", i, doneV[i], (k == lat) ? 1 : 0);
        if (k == lat) begin
          chk(dataTag, "resultData", i, dataV[i], expSum);
          chk("R5", "resultDst", i, dstV[i], d);
          if (noise) reqV[i] = 1'b0;
        end
      end
    end
    if (d != 0) model[d] = expSum;
  endtask

  task automatic testReset();
    for (int i = 0; i < NREG; i++) model[i] = DW'(i);
    for (int i = 0; i < 3; i++) begin
      chk("R1", "busy after reset", i, busyV[i], 0);
      chk("R1", "done after reset", i, doneV[i], 0);
    end
    runOp(9, 0, 0, 1'b0, "R1");
    runOp(15, 4, 0, 1'b0, "R1");
  endtask

  task automatic testSums();
    runOp(2, 3, 10, 1'b0, "R5");
    runOp(10, 10, 11, 1'b0, "R5");
    runOp(11, 0, 0, 1'b0, "R5");
    // wrap-around by repeated doubling of register 7
    for (int n = 0; n < 14; n++) runOp(7, 7, 7, 1'b0, "R5");
    runOp(7, 12, 13, 1'b0, "R5");
    runOp(13, 0, 0, 1'b0, "R5");
  endtask

  task automatic testZeroReg();
    runOp(0, 0, 4, 1'b0, "R6");
    runOp(6, 8, 0, 1'b0, "R6");
    runOp(0, 3, 0, 1'b0, "R6");
    runOp(4, 0, 0, 1'b0, "R6");
  endtask

  task automatic testAlias();
    runOp(3, 3, 3, 1'b0, "R7");
    runOp(3, 0, 0, 1'b0, "R7");
    runOp(14, 2, 2, 1'b0, "R7");
    runOp(2, 2, 0, 1'b0, "R7");
  endtask

  task automatic testBusyIgnore();
    runOp(4, 6, 8, 1'b1, "R8");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) chk("R8", "no extra done", i, doneV[i], 0);
    end
    runOp(5, 0, 0, 1'b0, "R8");
    runOp(8, 0, 0, 1'b0, "R8");
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rstN = 1'b0;
    reqV = 3'b000;
    sA = '0; sB = '0; dI = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSums();
    testZeroReg();
    testAlias();
    testBusyIgnore();
    summary();
  end

endmodule